// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block holds the interrupt logic for one port of general-purpose pins. Every pin gets its own detection type: rising edge, falling edge, either edge, high level or low level. When the selected event occurs on a pin, that pin's pending bit is latched. A per-pin enable mask is applied, and the enabled pending bits are combined into a single registered interrupt request.

The pin inputs are assumed to be synchronized already. Software-facing state reaches the block through three plain write strobes, each with its own data word:

- A type word holds three bits per pin.
- An enable word holds one bit per pin.
- A clear word is write-one-to-clear.

The block drives the pending-status vector and the request line. Address decoding and pad logic sit outside it. All pins are plain control and status signals with no handshake. A write is accepted in every cycle its strobe is high, so there is never any back-pressure.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is low, and in the first cycle after reset, the status vector and the request are all zero. The type word and the enable word reset to zero.
- R2: For pin n, the type word holds three bits: bit n is the polarity (1 = high or rising), bit n+8 selects edge mode (1 = edge, 0 = level), and bit n+16 selects both edges. The value 0x000101<<n selects a rising edge. A 0→1 change between the previous and current sample sets status bit n on the next clock.
- R3: The value 0x000100<<n selects a falling edge. A 1→0 change sets status bit n on the next clock.
- R4: The value 0x010100<<n selects both edges. Any change of pin n sets its status bit. The polarity bit is ignored in this mode.
- R5: The value 0x000001<<n selects a high level. Status bit n is set after every cycle in which the pin is 1.
- R6: All three bits clear (the reset value) selects a low level. Status bit n is set after every cycle in which the pin is 0.
- R7: A status bit stays set until a clear-strobe cycle writes 1 to its position. A 0 in the clear word leaves that bit unchanged.
- R8: If a clear of bit n and a new event on pin n fall in the same cycle, the bit stays set. A clear therefore has no effect while an active level persists.
- R9: The enable bits gate only the request. Status bits latch whether or not the pin is enabled.
- R10: The request equals the OR over all pins of (status AND enable), delayed by one register stage.
- R11: A type write that changes any of pin n's three bits discards that pin's sample history. In the cycle right after the write, no edge is reported for that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| type_wr_en | input | 1 | Type word write strobe |
| type_wr_data | input | 3*NUM_PINS | New type word |
| en_wr_en | input | 1 | Enable word write strobe |
| en_wr_data | input | NUM_PINS | New enable word |
| clr_wr_en | input | 1 | Clear strobe |
| clr_wr_data | input | NUM_PINS | Write-one-to-clear mask |
| irq_status | output | NUM_PINS | Latched pending bits |
| irq_req | output | 1 | Combined interrupt request |

## Verification
Directed patterns run each of the five detection types. Some pins toggle and others stay steady, so that a rising detector is seen to ignore falls and a level detector is seen to re-assert through a clear. A type change made in the same cycle as a pin transition tells whether sample history is really discarded. Partial clear masks tell per-bit clearing apart from whole-word clearing. A long random phase then mixes type, enable and clear writes with arbitrary pin activity. In every cycle, status and request are compared against a behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // One pin's slice of the type word
  typedef struct packed {
    logic dual;      // both edges
    logic edge_sel;  // 1 = edge, 0 = level
    logic pol;       // 1 = high / rising
  } det_cfg_t;

  typedef enum logic [2:0] {
    DET_LVL_LO    = 3'd0,
    DET_LVL_HI    = 3'd1,
    DET_EDGE_FALL = 3'd2,
    DET_EDGE_RISE = 3'd3,
    DET_EDGE_ANY  = 3'd4
  } det_mode_e;

  function automatic det_mode_e decode_mode(det_cfg_t c);
    det_mode_e m;
    if (!c.edge_sel)  m = c.pol ? DET_LVL_HI : DET_LVL_LO;
    else if (c.dual)  m = DET_EDGE_ANY;
    else              m = c.pol ? DET_EDGE_RISE : DET_EDGE_FALL;
    return m;
  endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
// Type and enable registers, plus per-pin detection of type changes
module gpio_irq_cfg #(
  parameter int NUM_PINS = 8,
  localparam int TYPE_W  = 3 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                type_wr_en,
  input  logic [TYPE_W-1:0]   type_wr_data,
  input  logic                en_wr_en,
  input  logic [NUM_PINS-1:0] en_wr_data,
  output logic [TYPE_W-1:0]   type_q,
  output logic [NUM_PINS-1:0] enable_q,
  output logic [NUM_PINS-1:0] hist_clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q   <= '0;
      enable_q <= '0;
    end else begin
      if (type_wr_en) type_q   <= type_wr_data;
      if (en_wr_en)   enable_q <= en_wr_data;
    end
  end

  // A write that alters any of a pin's three bits drops that pin's history
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chg
    logic [2:0] old_bits, new_bits;
    assign old_bits = {type_q[g+2*NUM_PINS], type_q[g+NUM_PINS], type_q[g]};
    assign new_bits = {type_wr_data[g+2*NUM_PINS], type_wr_data[g+NUM_PINS],
                       type_wr_data[g]};
    assign hist_clr[g] = type_wr_en && (old_bits != new_bits);
  end

endmodule

// File: rtl/gpio_irq_pin_det.sv
// One pin: sample history, event detection, pending latch
module gpio_irq_pin_det
  import gpio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin,
  input  det_cfg_t cfg,
  input  logic     hist_clr,
  input  logic     clr,
  output logic     status
);

  logic      prev_q;
  logic      hist_ok_q;
  logic      evt;
  det_mode_e mode;

  assign mode = decode_mode(cfg);

  always_comb begin
    unique case (mode)
      DET_LVL_LO:    evt = ~pin;
      DET_LVL_HI:    evt = pin;
      DET_EDGE_RISE: evt = hist_ok_q & pin & ~prev_q;
      DET_EDGE_FALL: evt = hist_ok_q & ~pin & prev_q;
      DET_EDGE_ANY:  evt = hist_ok_q & (pin ^ prev_q);
      default:       evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      hist_ok_q <= 1'b0;
      status    <= 1'b0;
    end else begin
      prev_q    <= pin;
      hist_ok_q <= ~hist_clr;
      // a new event outranks a clear in the same cycle
      status    <= (status & ~clr) | evt;
    end
  end

endmodule

// File: rtl/gpio_irq_combine.sv
// Masks pending bits by enable and registers the OR
module gpio_irq_combine #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] status,
  input  logic [NUM_PINS-1:0] enable,
  output logic                req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= |(status & enable);
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int TYPE_W  = 3 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                type_wr_en,
  input  logic [TYPE_W-1:0]   type_wr_data,
  input  logic                en_wr_en,
  input  logic [NUM_PINS-1:0] en_wr_data,
  input  logic                clr_wr_en,
  input  logic [NUM_PINS-1:0] clr_wr_data,
  output logic [NUM_PINS-1:0] irq_status,
  output logic                irq_req
);

  logic [TYPE_W-1:0]   type_q;
  logic [NUM_PINS-1:0] enable_q;
  logic [NUM_PINS-1:0] hist_clr;
  logic [NUM_PINS-1:0] clr_mask;

  assign clr_mask = clr_wr_en ? clr_wr_data : '0;

  gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) cfg_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .type_wr_en   (type_wr_en),
    .type_wr_data (type_wr_data),
    .en_wr_en     (en_wr_en),
    .en_wr_data   (en_wr_data),
    .type_q       (type_q),
    .enable_q     (enable_q),
    .hist_clr     (hist_clr)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    det_cfg_t pin_cfg;
    assign pin_cfg = '{dual:     type_q[g+2*NUM_PINS],
                       edge_sel: type_q[g+NUM_PINS],
                       pol:      type_q[g]};
    gpio_irq_pin_det det_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (pin_in[g]),
      .cfg      (pin_cfg),
      .hist_clr (hist_clr[g]),
      .clr      (clr_mask[g]),
      .status   (irq_status[g])
    );
  end

  gpio_irq_combine #(.NUM_PINS(NUM_PINS)) comb_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (irq_status),
    .enable (enable_q),
    .req    (irq_req)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NUM_PINS = 8,
  localparam int TYPE_W  = 3 * NUM_PINS
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_in,
  input logic                clr_wr_en,
  input logic [NUM_PINS-1:0] clr_wr_data,
  input logic [TYPE_W-1:0]   type_q,
  input logic [NUM_PINS-1:0] enable_q,
  input logic [NUM_PINS-1:0] irq_status,
  input logic                irq_req
);

  logic [NUM_PINS-1:0] keep_bits;
  logic [NUM_PINS-1:0] hi_active;

  assign keep_bits = irq_status & ~(clr_wr_en ? clr_wr_data : '0);
  assign hi_active = type_q[NUM_PINS-1:0] & ~type_q[2*NUM_PINS-1:NUM_PINS] & pin_in;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (irq_status == '0 && !irq_req));

  assert_level_high_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_status & $past(hi_active)) == $past(hi_active)));

  assert_pending_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_status & $past(keep_bits)) == $past(keep_bits)));

  assert_req_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_req == $past(|(irq_status & enable_q))));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_in      (pin_in),
  .clr_wr_en   (clr_wr_en),
  .clr_wr_data (clr_wr_data),
  .type_q      (type_q),
  .enable_q    (enable_q),
  .irq_status  (irq_status),
  .irq_req     (irq_req)
);

// File: tb/gpio_irq_detect_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb_top;
  localparam int N  = 8;
  localparam int TW = 3 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin_in = '0;
  logic          type_wr_en = 1'b0;
  logic [TW-1:0] type_wr_data = '0;
  logic          en_wr_en = 1'b0;
  logic [N-1:0]  en_wr_data = '0;
  logic          clr_wr_en = 1'b0;
  logic [N-1:0]  clr_wr_data = '0;
  logic [N-1:0]  irq_status;
  logic          irq_req;

  always #10 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .type_wr_en(type_wr_en), .type_wr_data(type_wr_data),
    .en_wr_en(en_wr_en), .en_wr_data(en_wr_data),
    .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
    .irq_status(irq_status), .irq_req(irq_req)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";
  bit    done   = 0;

  // behavioural reference state
  logic [TW-1:0] m_type;
  logic [N-1:0]  m_en, m_stat, m_prev, m_hv;
  logic          m_req;

  always @(posedge clk) begin : model
    logic [N-1:0] evt;
    logic [N-1:0] nhv;
    if (!rst_n) begin
      m_type = '0; m_en = '0; m_stat = '0; m_prev = '0; m_hv = '0; m_req = 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit pol, eg, du;
        pol = m_type[i]; eg = m_type[i+N]; du = m_type[i+2*N];
        if (!eg)     evt[i] = (pin_in[i] == pol);
        else if (du) evt[i] = m_hv[i] && (pin_in[i] != m_prev[i]);
        else if (pol) evt[i] = m_hv[i] && pin_in[i] && !m_prev[i];
        else         evt[i] = m_hv[i] && !pin_in[i] && m_prev[i];
      end
      m_req  = |(m_stat & m_en);
      m_stat = (m_stat & ~(clr_wr_en ? clr_wr_data : '0)) | evt;
      nhv = '1;
      if (type_wr_en)
        for (int i = 0; i < N; i++)
          if (type_wr_data[i] != m_type[i] || type_wr_data[i+N] != m_type[i+N] ||
              type_wr_data[i+2*N] != m_type[i+2*N]) nhv[i] = 1'b0;
      m_hv   = nhv;
      m_prev = pin_in;
      if (type_wr_en) m_type = type_wr_data;
      if (en_wr_en)   m_en   = en_wr_data;
    end
  end

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(irq_status === m_stat, phase, "status model", 32'(irq_status), 32'(m_stat));
    check(irq_req === m_req, phase, "request model", 32'(irq_req), 32'(m_req));
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr_type(logic [TW-1:0] v);
    type_wr_en = 1'b1; type_wr_data = v; step(); type_wr_en = 1'b0;
  endtask
  task automatic wr_en(logic [N-1:0] v);
    en_wr_en = 1'b1; en_wr_data = v; step(); en_wr_en = 1'b0;
  endtask
  task automatic wr_clr(logic [N-1:0] v);
    clr_wr_en = 1'b1; clr_wr_data = v; step(); clr_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset holds everything low
    phase = "R1";
    repeat (3) begin
      step();
      check(irq_status == '0 && !irq_req, "R1", "reset outputs",
            {23'd0, irq_req, irq_status}, 32'd0);
    end
    rst_n = 1'b1;
    // R6: reset type is low-level; pins low set all bits
    phase = "R6";
    step();
    check(irq_status == 8'hFF, "R6", "low level sets", 32'(irq_status), 32'hFF);
    check(!irq_req, "R9", "disabled pins give no request", 32'(irq_req), 32'd0);
    // R8: clear while level persists is overridden
    phase = "R8";
    wr_clr(8'hFF);
    check(irq_status == 8'hFF, "R8", "event beats clear", 32'(irq_status), 32'hFF);
    // R2: rising edge
    phase = "R2";
    wr_type(24'h00FFFF); step();
    wr_clr(8'hFF);
    check(irq_status == 8'h00, "R7", "clear all", 32'(irq_status), 32'h0);
    pin_in = 8'h05; step();
    check(irq_status == 8'h05, "R2", "rising edges", 32'(irq_status), 32'h05);
    // R3: falling edge
    phase = "R3";
    wr_type(24'h00FF00); step(); wr_clr(8'hFF);
    pin_in = 8'h04; step();
    check(irq_status == 8'h01, "R3", "falling edge", 32'(irq_status), 32'h01);
    // R4: both edges
    phase = "R4";
    wr_type(24'hFFFF00); step(); wr_clr(8'hFF);
    pin_in = 8'h0A; step();
    check(irq_status == 8'h0E, "R4", "any edge", 32'(irq_status), 32'h0E);
    // R5: high level survives a clear
    phase = "R5";
    wr_type(24'h0000FF); step(); wr_clr(8'hFF);
    check(irq_status == 8'h0A, "R5", "high level", 32'(irq_status), 32'h0A);
    // R7: partial clear, latch holds
    phase = "R7";
    wr_type(24'h00FFFF); step(); wr_clr(8'hFF);
    pin_in = 8'hFF; step();
    check(irq_status == 8'hF5, "R2", "rising from 0x0A", 32'(irq_status), 32'hF5);
    wr_clr(8'h0F);
    check(irq_status == 8'hF0, "R7", "partial clear", 32'(irq_status), 32'hF0);
    step();
    check(irq_status == 8'hF0, "R7", "bits latched", 32'(irq_status), 32'hF0);
    // R10: request one register after status&enable
    phase = "R10";
    wr_en(8'h10);
    check(!irq_req, "R10", "request lags enable", 32'(irq_req), 32'd0);
    step();
    check(irq_req, "R10", "request raised", 32'(irq_req), 32'd1);
    wr_clr(8'h10);
    check(irq_req, "R10", "request lags clear", 32'(irq_req), 32'd1);
    step();
    check(!irq_req, "R10", "request dropped", 32'(irq_req), 32'd0);
    check(irq_status == 8'hE0, "R9", "disabled bits stay pending", 32'(irq_status), 32'hE0);
    // R11: type change discards history
    phase = "R11";
    pin_in = 8'h00; step(); step();
    wr_type(24'h00FF00); step(); wr_clr(8'hFF);
    wr_type(24'h00FFFF);
    pin_in = 8'hFF; step();
    check(irq_status == 8'h00, "R11", "no edge after type change", 32'(irq_status), 32'h0);
    pin_in = 8'h00; step();
    pin_in = 8'hFF; step();
    check(irq_status == 8'hFF, "R11", "history restored", 32'(irq_status), 32'hFF);
    // random mix, every requirement compared against the model
    phase = "random";
    for (int c = 0; c < 4000; c++) begin
      pin_in       = N'($urandom);
      type_wr_en   = ($urandom % 20) == 0;
      type_wr_data = TW'($urandom);
      en_wr_en     = ($urandom % 20) == 0;
      en_wr_data   = N'($urandom);
      clr_wr_en    = ($urandom % 8) == 0;
      clr_wr_data  = N'($urandom);
      step();
    end
    type_wr_en = 1'b0; en_wr_en = 1'b0; clr_wr_en = 1'b0;
    step();
    finish_run();
  end

endmodule